// File: doc/BRIEF.md
# Counter-Sequenced Serial Flash Byte Master

This block moves one byte at a time between a host and a serial NOR flash over a single-lane SPI link. The host places a byte on `tx_byte` and pulses `start`. The block shifts that byte out on `mosi` while shifting a byte in from `miso`. When the transfer ends it presents the received byte on `rx_byte`, drops `busy` and pulses `done`. Chip select is a level the host owns through `cs_req`, so a whole flash command can be framed as several bytes inside one select period: an opcode, address bytes, then data or ID bytes. Putting the commands in order is left to the host.

All timing comes from a single up counter. Its low field is the phase within one serial bit, the middle field is the bit index, and its top bit is the busy flag. The busy flag clears when the counter overflows after the last bit. With the default divide of four, the serial clock is a quarter of the system clock, so a system clock near 160 MHz gives about 40 MHz on the link. The link runs in mode 0. Each incoming bit is captured on the final system clock edge of the serial clock's high half, which gives the flash's output the most settling time.

Top module: `spi_flash_xfer`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `cs_n` is 1, and `sclk`, `mosi`, `busy`, `done` and `rx_byte` are all 0.
- R2: `sclk` is low whenever `busy` is low. During a transfer each bit spans 4 system cycles: 2 with `sclk` low, then 2 with `sclk` high. A byte gives exactly 8 rising edges.
- R3: `mosi` carries `tx_byte` most significant bit first. Each bit is presented from the first low cycle of its bit period and holds steady while `sclk` is high. `mosi` is 0 when idle.
- R4: `miso` is sampled on the system clock edge that ends the second high cycle of `sclk`, most significant bit first. The value on `miso` in earlier cycles of the bit has no effect.
- R5: A `start` seen at a clock edge while `busy` is low makes `busy` high from the next cycle for 32 cycles. In the 33rd cycle after that edge, `busy` is low, `done` is high for that one cycle, and `rx_byte` holds the new byte.
- R6: A `start` that arrives while `busy` is high is ignored. It changes neither the byte being sent nor the timing of the current transfer.
- R7: `rx_byte` changes only in the cycle where `done` is high. Otherwise it keeps its value, including during the next transfer.
- R8: `cs_n` takes the inverse of `cs_req` one cycle after a clock edge at which `busy` is low. While `busy` is high, `cs_n` does not change. Several bytes may be sent within one low period of `cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_byte | input | 8 | Byte to send, taken when a transfer is accepted |
| cs_req | input | 1 | Host request to assert chip select (1 = select) |
| start | input | 1 | Begin one byte transfer |
| miso | input | 1 | Serial data from the flash |
| rx_byte | output | 8 | Last byte received |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer completes |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
Counting from the clock edge that accepts `start`, `busy` is expected in the very next cycle. The expected levels of `sclk` and `mosi` in cycle k follow from (k-1) mod 4 and (k-1)/4. `done` and the new `rx_byte` are due exactly in cycle 33, and a change of `cs_n` is due one cycle after the first idle edge. The bench counts negative clock edges from the edge where it drives `start`, and it compares each output only at the negative edge that falls in the due cycle. The flash model drives the correct `miso` bit only in the second high cycle of `sclk` and drives the inverted bit in every other cycle. Any capture outside that cycle therefore shows up as a wrong `rx_byte` in cycle 33.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

   // Taps decoded from the single sequencing counter.
   typedef struct packed {
      logic busy;     // top counter bit
      logic sclk;     // upper half of the phase field
      logic capture;  // last system cycle of a bit period
      logic last;     // final cycle of the final bit
   } seq_taps_t;

   function automatic int unsigned seq_cnt_bits(input int unsigned data_w,
                                                input int unsigned div_log2);
      return div_log2 + $clog2(data_w) + 1;
   endfunction

endpackage

// File: rtl/spi_seq_counter.sv
module spi_seq_counter
   import spi_xfer_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      launch,
   output seq_taps_t taps
);
   localparam int unsigned IDX_W  = $clog2(DATA_W);
   localparam int unsigned CNT_W  = seq_cnt_bits(DATA_W, DIV_LOG2);
   localparam int unsigned BUSY_B = CNT_W - 1;

   generate
      if (DATA_W != (1 << IDX_W)) begin : g_bad_width
         $error("DATA_W must be a power of two");
      end
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("DIV_LOG2 must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0]    cnt;
   logic [DIV_LOG2-1:0] phase;

   // Busy is the top bit; overflow after the last bit clears it.
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (launch && !cnt[BUSY_B])
         cnt <= {1'b1, {(CNT_W-1){1'b0}}};
      else if (cnt[BUSY_B])
         cnt <= cnt + 1'b1;
   end

   assign phase        = cnt[DIV_LOG2-1:0];
   assign taps.busy    = cnt[BUSY_B];
   assign taps.sclk    = cnt[BUSY_B] & cnt[DIV_LOG2-1];
   assign taps.capture = cnt[BUSY_B] & (&phase);
   assign taps.last    = &cnt;

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              capture,
   input  logic              last,
   input  logic              active,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_data
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shifted;

   assign shifted = {shreg[DATA_W-2:0], miso};

   // One register both sends (top bit) and receives (bottom bit).
   always_ff @(posedge clk) begin
      if (!rst_n)
         shreg <= '0;
      else if (load)
         shreg <= load_data;
      else if (capture)
         shreg <= shifted;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rx_data <= '0;
      else if (last)
         rx_data <= shifted;
   end

   assign mosi = active & shreg[DATA_W-1];

endmodule

// File: rtl/spi_cs_gate.sv
module spi_cs_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic cs_req,
   output logic cs_n
);
   // Select may only move between bytes.
   always_ff @(posedge clk) begin
      if (!rst_n)
         cs_n <= 1'b1;
      else if (!active)
         cs_n <= ~cs_req;
   end
endmodule

// File: rtl/spi_flash_xfer.sv
module spi_flash_xfer
   import spi_xfer_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned DIV_LOG2 = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic              cs_req,
   input  logic              start,
   input  logic              miso,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy,
   output logic              done,
   output logic              sclk,
   output logic              mosi,
   output logic              cs_n
);
   seq_taps_t taps;
   logic      accept;

   assign accept = start & ~taps.busy;

   spi_seq_counter #(.DATA_W(DATA_W), .DIV_LOG2(DIV_LOG2)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (start),
      .taps   (taps)
   );

   spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_data (tx_byte),
      .capture   (taps.capture),
      .last      (taps.last),
      .active    (taps.busy),
      .miso      (miso),
      .mosi      (mosi),
      .rx_data   (rx_byte)
   );

   spi_cs_gate u_cs (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (taps.busy),
      .cs_req (cs_req),
      .cs_n   (cs_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         done <= 1'b0;
      else
         done <= taps.last;
   end

   assign busy = taps.busy;
   assign sclk = taps.sclk;

endmodule

// File: rtl/spi_flash_xfer_chk.sv
module spi_flash_xfer_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [DATA_W-1:0] rx_byte,
   input logic              busy,
   input logic              done,
   input logic              sclk,
   input logic              mosi,
   input logic              cs_n
);
   a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   a_r2_sclk_high_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |=> sclk);

   a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(mosi));

   a_r5_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   a_r7_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_byte) |-> done);

   a_r8_cs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cs_n));
endmodule

bind spi_flash_xfer spi_flash_xfer_chk #(.DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .rx_byte (rx_byte),
   .busy    (busy),
   .done    (done),
   .sclk    (sclk),
   .mosi    (mosi),
   .cs_n    (cs_n)
);

// File: tb/tb_spi_flash_xfer.sv
module tb_spi_flash_xfer;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] tx_byte;
   logic       cs_req;
   logic       start;
   logic       miso;
   logic [7:0] rx_byte;
   logic       busy, done, sclk, mosi, cs_n;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   spi_flash_xfer dut (
      .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .cs_req(cs_req),
      .start(start), .miso(miso), .rx_byte(rx_byte), .busy(busy),
      .done(done), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
   );

   // Fixed identification / data stream returned by the flash model.
   function automatic logic [7:0] id_byte(input int k);
      return 8'((k * 29) ^ 8'h5A);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Flash model: correct bit only in the second high cycle of sclk.
   int         bitcnt   = 0;
   int         rise_cnt = 0;
   logic       prev_sclk = 1'b0;
   logic [7:0] mosi_sh  = 8'h00;
   always @(negedge clk) begin
      logic [7:0] cur;
      logic       b;
      if (cs_n !== 1'b0) begin
         bitcnt = 0;
      end else begin
         if (!sclk && prev_sclk) bitcnt = bitcnt + 1;
         if (sclk && !prev_sclk) begin
            mosi_sh  = {mosi_sh[6:0], mosi};
            rise_cnt = rise_cnt + 1;
         end
      end
      cur  = id_byte(bitcnt / 8);
      b    = cur[7 - (bitcnt % 8)];
      miso = (sclk && prev_sclk) ? b : ~b;
      prev_sclk = sclk;
   end

   // One byte transfer; the start edge is E0, negedge k follows edge k-1.
   task automatic xfer(input logic [7:0] tx, input logic [7:0] exp_rx,
                       input bit poke_start, input bit poke_cs);
      int         rise0;
      logic [7:0] old_rx;
      logic       cs_before;
      rise0     = rise_cnt;
      old_rx    = rx_byte;
      cs_before = cs_n;
      @(negedge clk);
      tx_byte = tx;
      start   = 1'b1;
      for (int k = 1; k <= 32; k++) begin
         @(negedge clk);
         start = 1'b0;
         if (k == 1) chk(busy === 1'b1, "R5", "busy after start", busy, 1);
         chk(sclk === ((((k - 1) % 4) >= 2) ? 1'b1 : 1'b0), "R2", "sclk phase",
             sclk, (((k - 1) % 4) >= 2) ? 1 : 0);
         chk(mosi === tx[7 - (k - 1) / 4], "R3", "mosi bit", mosi, tx[7 - (k - 1) / 4]);
         if (k == 10 && poke_start) begin
            start   = 1'b1;
            tx_byte = ~tx;
         end
         if (k == 12 && poke_cs) cs_req = ~cs_req;
         if (k == 14) chk(cs_n === cs_before, "R8", "cs_n frozen", cs_n, cs_before);
         if (k == 20) chk(rx_byte === old_rx, "R7", "rx held mid-transfer", rx_byte, old_rx);
         if (k == 32) chk(busy === 1'b1 && done === 1'b0, "R5", "busy in cycle 32",
                          {busy, done}, 2'b10);
      end
      @(negedge clk);
      chk(done === 1'b1 && busy === 1'b0, "R5", "done in cycle 33", {busy, done}, 2'b01);
      chk(rx_byte === exp_rx, "R4", "received byte", rx_byte, exp_rx);
      chk(mosi_sh === tx, poke_start ? "R6" : "R3", "byte seen by flash", mosi_sh, tx);
      chk(rise_cnt - rise0 == 8, "R2", "rising edges per byte", rise_cnt - rise0, 8);
      chk(sclk === 1'b0 && mosi === 1'b0, "R2", "idle sclk/mosi", {sclk, mosi}, 0);
      @(negedge clk);
      chk(done === 1'b0, "R5", "done one cycle", done, 0);
      chk(cs_n === ~cs_req, "R8", "cs_n follows request", cs_n, ~cs_req);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] held;
      rst_n = 1'b0; tx_byte = 8'h00; cs_req = 1'b0; start = 1'b0;
      repeat (3) @(negedge clk);
      chk(cs_n === 1'b1, "R1", "reset cs_n", cs_n, 1);
      chk({sclk, mosi, busy, done} === 4'b0, "R1", "reset controls",
          {sclk, mosi, busy, done}, 0);
      chk(rx_byte === 8'h00, "R1", "reset rx_byte", rx_byte, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n === 1'b1 && busy === 1'b0, "R1", "first cycle after reset", {cs_n, busy}, 2'b10);

      // Frame 1: ID-style read, with a stray start in the middle byte.
      cs_req = 1'b1;
      @(negedge clk);
      chk(cs_n === 1'b0, "R8", "select asserted", cs_n, 0);
      xfer(8'h9F, id_byte(0), 1'b0, 1'b0);
      xfer(8'h00, id_byte(1), 1'b1, 1'b0);
      xfer(8'hFF, id_byte(2), 1'b0, 1'b0);
      held = rx_byte;
      repeat (5) @(negedge clk);
      chk(rx_byte === held, "R7", "rx held while idle", rx_byte, held);
      chk(sclk === 1'b0 && busy === 1'b0, "R2", "idle between bytes", {sclk, busy}, 0);
      cs_req = 1'b0;
      repeat (2) @(negedge clk);
      chk(cs_n === 1'b1, "R8", "select released", cs_n, 1);

      // Frame 2: every transmit value, stream restarts at byte 0.
      cs_req = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 256; i++) xfer(8'(i), id_byte(i), 1'b0, (i == 255));
      repeat (2) @(negedge clk);
      chk(cs_n === 1'b1, "R8", "release after frame", cs_n, 1);

      // Frame 3: select drop requested mid-byte; next frame restarts.
      cs_req = 1'b1;
      repeat (2) @(negedge clk);
      xfer(8'hA5, id_byte(0), 1'b1, 1'b1);
      summary();
   end
endmodule